// File: doc/BRIEF.md
# Byte-Lane Synchronous SRAM with Selectable Read Latency

This block is a behavioural synchronous SRAM for on-chip modelling. Its word is 32 bits wide, split into four byte lanes, and its depth is set by the address width parameter. The rising clock edge registers the address, the chip selects, the write controls and the write data in one input stage. The memory array commits a write one edge after capture. Reads return either straight from the array (flow-through) or through an output register (pipelined), as a static mode input selects. The address comes from an external burst sequencer, so every selected cycle is an independent access.

The data bus is modelled as a separate write-data input and a read-data output with a drive-enable output. A low drive enable stands for a high-impedance bus. An asynchronous active-low output enable and an asynchronous active-high sleep input both force the drive enable low. Sleep also blocks accesses and keeps the stored contents. A deselect or a write turns the drive off after a single register stage past capture, with no second deselect stage.

Top module: `sync_sram_bw`

## Requirements
- R1: An access is captured only when `ce1_ni` is low, `ce2_i` is high, `ce3_ni` is low and `sleep_i` is low at the clock edge. Any other combination writes nothing and starts no read.
- R2: With `gw_ni` low, a selected cycle writes all four lanes of `wdata_i`, whatever the values of `bwe_ni` and `bsel_ni`.
- R3: With `gw_ni` high and `bwe_ni` low, a selected cycle writes exactly the lanes whose `bsel_ni` bit is low. Lane l is bits 8l+7..8l and is controlled by `bsel_ni[l]`. The other lanes keep their contents.
- R4: A selected cycle that writes no lane is a read. It returns the word at the captured address, including every write captured on an earlier edge, and that includes the edge just before.
- R5: With `pipe_i` low, a read captured at edge k drives `dq_o` with `dq_oe_o` high in the cycle after edge k.
- R6: With `pipe_i` high, a read captured at edge k drives `dq_o` with `dq_oe_o` high in the cycle after edge k+1.
- R7: In a cycle that carries no read result, `dq_oe_o` is low, including the cycle that follows a captured write or deselect.
- R8: `oe_ni` high forces `dq_oe_o` low without waiting for a clock edge and leaves the read pipeline and memory undisturbed.
- R9: `sleep_i` high forces `dq_oe_o` low without waiting for a clock edge and blocks accesses captured while it is high. Stored words are kept.
- R10: While `rst_ni` is low, `dq_oe_o` is low. Reset clears the control state but not the memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pipe_i | input | 1 | Read mode: 1 pipelined, 0 flow-through (static) |
| addr_i | input | AW | Word address |
| ce1_ni | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| ce3_ni | input | 1 | Chip enable, active low |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte-write enable, active low |
| bsel_ni | input | 4 | Per-lane write selects, active low |
| wdata_i | input | 32 | Write data |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Asynchronous sleep, active high |
| dq_o | output | 32 | Read data |
| dq_oe_o | output | 1 | Bus drive enable (low means high impedance) |

## Verification
The bench builds the block with `AW` set to 4, which gives 16 words. With so few words, random traffic lands on the same word many times. Partial writes therefore overlap earlier global writes, and a read often follows a write to the same word on the very next edge. Both read modes run the same directed and random sequences, so the latency offset of one register and the turn-off timing after writes and deselects are both exercised.

// File: rtl/sram_bw_pkg.sv
package sram_bw_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lane_t;
endpackage

// File: rtl/sram_bw_in_stage.sv
module sram_bw_in_stage
  import sram_bw_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          ce1_ni,
  input  logic          ce2_i,
  input  logic          ce3_ni,
  input  logic          gw_ni,
  input  logic          bwe_ni,
  input  lane_t         bsel_ni,
  input  logic          sleep_i,
  input  word_t         wdata_i,
  output logic [AW-1:0] addr_q_o,
  output lane_t         we_q_o,
  output logic          rd_q_o,
  output word_t         wdata_q_o
);
  logic  sel;
  lane_t lane_we;

  assign sel = !ce1_ni && ce2_i && !ce3_ni && !sleep_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane_dec
    assign lane_we[l] = sel && (!gw_ni || (!bwe_ni && !bsel_ni[l]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q_o <= '0;
      rd_q_o <= 1'b0;
    end else begin
      we_q_o <= lane_we;
      rd_q_o <= sel && (lane_we == '0);
    end
  end

  always_ff @(posedge clk_i) begin
    addr_q_o  <= addr_i;
    wdata_q_o <= wdata_i;
  end
endmodule

// File: rtl/sram_bw_array.sv
module sram_bw_array
  import sram_bw_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  lane_t         we_i,
  input  logic [AW-1:0] addr_i,
  input  word_t         wdata_i,
  output word_t         rdata_o
);
  localparam int DEPTH = 1 << AW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i[l]) mem[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = mem[addr_i];
  end
endmodule

// File: rtl/sram_bw_out_stage.sv
module sram_bw_out_stage
  import sram_bw_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pipe_i,
  input  logic  rd_i,
  input  word_t rdata_i,
  input  logic  oe_ni,
  input  logic  sleep_i,
  output word_t dq_o,
  output logic  dq_oe_o
);
  word_t dout_q;
  logic  vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= rd_i;
  end

  always_ff @(posedge clk_i) begin
    if (rd_i) dout_q <= rdata_i;
  end

  // single register stage for both data and turn-off
  assign dq_o    = pipe_i ? dout_q : rdata_i;
  assign dq_oe_o = (pipe_i ? vld_q : rd_i) && !oe_ni && !sleep_i;
endmodule

// File: rtl/sync_sram_bw.sv
module sync_sram_bw
  import sram_bw_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pipe_i,
  input  logic [AW-1:0] addr_i,
  input  logic          ce1_ni,
  input  logic          ce2_i,
  input  logic          ce3_ni,
  input  logic          gw_ni,
  input  logic          bwe_ni,
  input  logic [3:0]    bsel_ni,
  input  logic [31:0]   wdata_i,
  input  logic          oe_ni,
  input  logic          sleep_i,
  output logic [31:0]   dq_o,
  output logic          dq_oe_o
);
  logic [AW-1:0] cap_addr;
  lane_t         cap_we;
  logic          cap_rd;
  word_t         cap_wdata;
  word_t         arr_rdata;

  sram_bw_in_stage #(.AW(AW)) i_in_stage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .ce1_ni    (ce1_ni),
    .ce2_i     (ce2_i),
    .ce3_ni    (ce3_ni),
    .gw_ni     (gw_ni),
    .bwe_ni    (bwe_ni),
    .bsel_ni   (bsel_ni),
    .sleep_i   (sleep_i),
    .wdata_i   (wdata_i),
    .addr_q_o  (cap_addr),
    .we_q_o    (cap_we),
    .rd_q_o    (cap_rd),
    .wdata_q_o (cap_wdata)
  );

  sram_bw_array #(.AW(AW)) i_array (
    .clk_i   (clk_i),
    .we_i    (cap_we),
    .addr_i  (cap_addr),
    .wdata_i (cap_wdata),
    .rdata_o (arr_rdata)
  );

  sram_bw_out_stage i_out_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pipe_i  (pipe_i),
    .rd_i    (cap_rd),
    .rdata_i (arr_rdata),
    .oe_ni   (oe_ni),
    .sleep_i (sleep_i),
    .dq_o    (dq_o),
    .dq_oe_o (dq_oe_o)
  );
endmodule

// File: rtl/sram_bw_chk.sv
module sram_bw_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pipe_i,
  input logic       ce1_ni,
  input logic       ce2_i,
  input logic       ce3_ni,
  input logic       gw_ni,
  input logic       bwe_ni,
  input logic [3:0] bsel_ni,
  input logic       oe_ni,
  input logic       sleep_i,
  input logic       dq_oe_o,
  input logic [3:0] cap_we,
  input logic       cap_rd
);
  logic sel_in, rd_req;
  assign sel_in = !ce1_ni && ce2_i && !ce3_ni && !sleep_i;
  assign rd_req = sel_in && gw_ni && (bwe_ni || (bsel_ni == 4'hF));

  a_r1_desel_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_in |=> (cap_we == 4'h0 && !cap_rd));

  a_r2_global_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_in && !gw_ni) |=> (cap_we == 4'hF));

  a_r3_lane_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_in && gw_ni && !bwe_ni) |=> (cap_we == ~$past(bsel_ni)));

  a_r5_flow_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pipe_i && !oe_ni && !sleep_i && $past(rst_ni)) |-> (dq_oe_o == $past(rd_req)));

  a_r6_pipe_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_i && $past(pipe_i) && !oe_ni && !sleep_i && $past(rst_ni) && $past(rst_ni, 2))
      |-> (dq_oe_o == $past(rd_req, 2)));

  a_r8_oe_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !dq_oe_o);

  a_r9_sleep_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !dq_oe_o);
endmodule

bind sync_sram_bw sram_bw_chk i_sram_bw_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pipe_i  (pipe_i),
  .ce1_ni  (ce1_ni),
  .ce2_i   (ce2_i),
  .ce3_ni  (ce3_ni),
  .gw_ni   (gw_ni),
  .bwe_ni  (bwe_ni),
  .bsel_ni (bsel_ni),
  .oe_ni   (oe_ni),
  .sleep_i (sleep_i),
  .dq_oe_o (dq_oe_o),
  .cap_we  (cap_we),
  .cap_rd  (cap_rd)
);

// File: tb/test_sync_sram_bw.sv
module test_sync_sram_bw;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          pipe_i = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic          ce1_ni = 1'b1, ce2_i = 1'b0, ce3_ni = 1'b1;
  logic          gw_ni = 1'b1, bwe_ni = 1'b1;
  logic [3:0]    bsel_ni = 4'hF;
  logic [31:0]   wdata_i = '0;
  logic          oe_ni = 1'b0, sleep_i = 1'b0;
  logic [31:0]   dq_o;
  logic          dq_oe_o;

  sync_sram_bw #(.AW(AW)) i_sync_sram_bw (
    .clk_i, .rst_ni, .pipe_i, .addr_i, .ce1_ni, .ce2_i, .ce3_ni,
    .gw_ni, .bwe_ni, .bsel_ni, .wdata_i, .oe_ni, .sleep_i, .dq_o, .dq_oe_o
  );

  always #2.5 clk_i = ~clk_i;

  typedef struct {
    int          due;
    logic [31:0] data;
    string       req;
  } item_t;

  item_t       sb[$];
  logic [31:0] shadow [DEPTH];
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  bit          mon_on = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // driver: one access per cycle, expected reads go to the scoreboard
  task automatic op(input bit c1n, input bit c2, input bit c3n, input bit gwn,
                    input bit bwen, input logic [3:0] bsn, input logic [AW-1:0] a,
                    input logic [31:0] d, input bit oen, input bit slp);
    bit   sel;
    bit   wrote;
    item_t it;
    @(posedge clk_i); #1;
    ce1_ni = c1n; ce2_i = c2; ce3_ni = c3n; gw_ni = gwn; bwe_ni = bwen;
    bsel_ni = bsn; addr_i = a; wdata_i = d; oe_ni = oen; sleep_i = slp;
    sel = !c1n && c2 && !c3n && !slp;
    wrote = 1'b0;
    if (sel) begin
      for (int l = 0; l < 4; l++) begin
        if (!gwn || (!bwen && !bsn[l])) begin
          shadow[a][l*8 +: 8] = d[l*8 +: 8];
          wrote = 1'b1;
        end
      end
      if (!wrote) begin
        it.due  = cyc + (pipe_i ? 2 : 1);
        it.data = shadow[a];
        it.req  = pipe_i ? "R6" : "R5";
        sb.push_back(it);
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(1, 0, 1, 1, 1, 4'hF, '0, '0, 0, 0);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    op(0, 1, 0, 1, 1, 4'hF, a, '0, 0, 0);
  endtask

  // monitor: compares drive enable every cycle and data when a result is due
  always @(negedge clk_i) begin
    if (rst_ni && mon_on) begin
      bit    exp_oe;
      string tag;
      exp_oe = 1'b0;
      tag = oe_ni ? "R8" : (sleep_i ? "R9" : "R7");
      if (sb.size() != 0 && sb[0].due == cyc) begin
        item_t it;
        it = sb.pop_front();
        exp_oe = !oe_ni && !sleep_i;
        if (exp_oe) begin
          tag = it.req;
          checks++;
          if (dq_o !== it.data) begin
            errors++;
            $display("FAIL R4/%s data: actual %h expected %h", it.req, dq_o, it.data);
          end
        end
      end
      checks++;
      if (dq_oe_o !== exp_oe) begin
        errors++;
        $display("FAIL %s drive: actual %b expected %b", tag, dq_oe_o, exp_oe);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    checks++;  // R10: no drive while in reset
    if (dq_oe_o !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset drive: actual %b expected 0", dq_oe_o);
    end
    @(posedge clk_i); #1 rst_ni = 1'b1;
    for (int a = 0; a < DEPTH; a++)
      op(0, 1, 0, 0, 1, 4'hF, a[AW-1:0], 32'h1000_0000 + a, 0, 0);
    idle(3);
    mon_on = 1'b1;

    for (int m = 0; m < 2; m++) begin
      idle(3);
      pipe_i = (m == 0);
      idle(2);
      // R2: global write ignores byte controls
      op(0, 1, 0, 0, 0, 4'hF, 4'd3, 32'hA5A5_5A5A, 0, 0);
      rd(4'd3);                                   // R4 read right after write
      // R3: lanes 0 and 2 only
      op(0, 1, 0, 1, 0, 4'b1010, 4'd3, 32'h1122_3344, 0, 0);
      rd(4'd3);
      // R1: each enable alone deselects
      op(0, 0, 0, 0, 0, 4'h0, 4'd3, 32'hFFFF_FFFF, 0, 0);
      op(1, 1, 0, 0, 0, 4'h0, 4'd3, 32'hFFFF_FFFF, 0, 0);
      op(0, 1, 1, 0, 0, 4'h0, 4'd3, 32'hFFFF_FFFF, 0, 0);
      rd(4'd3);
      // R7: back-to-back reads, then write, then deselect
      rd(4'd1); rd(4'd2);
      op(0, 1, 0, 1, 0, 4'b0111, 4'd2, 32'hC0DE_0000, 0, 0);
      rd(4'd2);
      idle(3);
      // R8: output enable held high over a due result
      rd(4'd7);
      op(1, 0, 1, 1, 1, 4'hF, '0, '0, 1, 0);
      op(1, 0, 1, 1, 1, 4'hF, '0, '0, 1, 0);
      rd(4'd7);
      idle(3);
      // R9: sleep blocks a write and a read, contents kept
      op(0, 1, 0, 0, 1, 4'hF, 4'd5, 32'hDEAD_BEEF, 0, 1);
      op(0, 1, 0, 1, 1, 4'hF, 4'd5, '0, 0, 1);
      op(1, 0, 1, 1, 1, 4'hF, '0, '0, 0, 1);
      rd(4'd5);
      idle(3);
      // random traffic
      for (int i = 0; i < 400; i++) begin
        int k;
        k = $urandom % 6;
        case (k)
          0: op(0, 1, 0, 0, 1'($urandom), 4'($urandom), 4'($urandom), $urandom, 0, 0);
          1: op(0, 1, 0, 1, 0, 4'($urandom), 4'($urandom), $urandom, 0, 0);
          2, 3: rd(4'($urandom));
          4: op(1'($urandom), 1'($urandom), 1, 1'($urandom), 1'($urandom),
                4'($urandom), 4'($urandom), $urandom, 0, 0);
          default: op(0, 1, 0, 1, 1, 4'hF, 4'($urandom), '0, 1'($urandom % 4 == 0), 0);
        endcase
      end
      idle(4);
    end

    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R4 pending reads: actual %0d expected 0", sb.size());
    end
    report();
    $finish;
  end
endmodule